// File: doc/BRIEF.md
# Requester ID to Stream ID Lookup Table

This block translates the 16-bit bus/device/function identifier of an incoming request into a stream identifier. Downstream logic uses that stream identifier for address translation and for interrupt routing. The table holds a fixed number of entries. Software programs each entry through a simple write-only register port, one 32-bit word at a time.

An entry has two words. The upper word holds a requester ID and a per-bit compare mask. The lower word holds a stream ID and an enable flag. The ID presented with a request is first made relative to the controller's first bus number. It is then compared against every enabled entry at once, and the stream ID of the lowest-indexed match is returned one cycle later together with a hit flag.

A separate allocator hands out entry indices in ascending order starting from zero. Software asks it for a slot with a single-cycle pulse, and it raises a full indication once every entry has been claimed.

Top module: `rid_stream_map`

## Requirements
- R1: After reset every entry is disabled with a zero mask, respValid, respHit and respSid are zero, allocIdx is 0 and allocFull is low.
- R2: A write with regAddr[0]=0 loads the upper word of entry regAddr[IDX_W:1]. Bits 31:16 become the entry's requester ID and bits 15:0 its compare mask.
- R3: A write with regAddr[0]=1 loads the lower word of that entry. Bit 31 becomes its enable flag and bits SID_W-1:0 its stream ID. Bits 30:SID_W are ignored.
- R4: An enabled entry matches when every ID bit whose mask bit is 0 equals the relative request ID. A mask bit of 1 removes that bit from the compare, and a zero mask demands an exact match.
- R5: An entry whose enable flag is 0 never matches, whatever its ID and mask.
- R6: When several enabled entries match, the stream ID of the lowest index is returned.
- R7: When no entry matches, respHit is 0 and respSid is 0 while respValid is 1.
- R8: respValid is high exactly in the cycle after a cycle with reqValid high. While respValid is low, respHit and respSid are 0.
- R9: The ID used for matching is reqRid minus {baseBus, 8'h00}, taken modulo 2^16.
- R10: Each allocReq pulse while not full hands out the current allocIdx and advances it by one, starting at 0. After NUM_ENTRIES grants, allocFull goes high and stays high, allocIdx reads 0, and further pulses have no effect.
- R11: A lookup in the same cycle as a table write sees the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | IDX_W+1 | Bit 0 selects the word (0 upper, 1 lower); the upper bits give the entry index |
| regWrData | input | 32 | Register write data |
| baseBus | input | 8 | First bus number of the controller |
| reqValid | input | 1 | Lookup request valid |
| reqRid | input | 16 | Absolute requester ID of the request |
| respValid | output | 1 | Lookup result valid, one cycle after reqValid |
| respHit | output | 1 | An enabled entry matched |
| respSid | output | SID_W | Stream ID of the winning entry, 0 on a miss |
| allocReq | input | 1 | Claim the next free entry index |
| allocIdx | output | IDX_W | Next free entry index, 0 when full |
| allocFull | output | 1 | Every entry has been claimed |

## Verification
The hardest case to reach from the ports is overlapping matches. Two enabled entries, one masked and one exact, must both match the same request so that the priority order decides the result. The stimulus sets this up with a masked entry at a lower index that covers an exact entry at a higher index. It then disables the lower entry so that the higher one takes over.

A write and a lookup are also issued to the same entry in one cycle, to show which table contents the lookup sees. A reference model in the bench compares every output on every clock while baseBus is moved off zero and the allocator is driven through full.

// File: rtl/rid_map_pkg.sv
package rid_map_pkg;

  localparam int RID_W = 16;
  localparam int WORD_W = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic wrUpper;
    logic wrLower;
    logic lookup;
  } ctlStrobes_t;

endpackage

// File: rtl/rid_map_ctrl.sv
module rid_map_ctrl
  import rid_map_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [IDX_W:0]   regAddr,
  input  logic             reqValid,
  input  logic             allocReq,
  output ctlStrobes_t      stb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] allocIdx,
  output logic             allocFull
);

  localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

  logic [CNT_W-1:0] allocPtr;
  logic             idxOk;

  assign wrIdx = regAddr[IDX_W:1];
  // drop writes to indices beyond the table (non power-of-two depths)
  assign idxOk = (CNT_W'(wrIdx) < CNT_W'(NUM_ENTRIES));

  always_comb begin
    stb.wrUpper = regWrEn & idxOk & ~regAddr[0];
    stb.wrLower = regWrEn & idxOk & regAddr[0];
    stb.lookup  = reqValid;
  end

  assign allocFull = (allocPtr == CNT_W'(NUM_ENTRIES));
  assign allocIdx  = allocFull ? '0 : allocPtr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allocPtr <= '0;
    end else if (allocReq && !allocFull) begin
      allocPtr <= allocPtr + CNT_W'(1);
    end
  end

endmodule

// File: rtl/rid_map_dp.sv
module rid_map_dp
  import rid_map_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int SID_W = 10,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        stb,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [WORD_W-1:0]  regWrData,
  input  logic [7:0]         baseBus,
  input  logic [RID_W-1:0]   reqRid,
  output logic               respValid,
  output logic               respHit,
  output logic [SID_W-1:0]   respSid
);

  logic [RID_W-1:0]       ridTab  [NUM_ENTRIES];
  logic [RID_W-1:0]       maskTab [NUM_ENTRIES];
  logic [SID_W-1:0]       sidTab  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] enTab;
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [RID_W-1:0]       relRid;
  logic                   anyHit;
  logic [SID_W-1:0]       selSid;
  logic                   unusedBits;

  assign unusedBits = ^regWrData[WORD_W-2:SID_W];

  // table storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ridTab[i]  <= '0;
        maskTab[i] <= '0;
        sidTab[i]  <= '0;
      end
      enTab <= '0;
    end else begin
      if (stb.wrUpper) begin
        ridTab[wrIdx]  <= regWrData[WORD_W-1:RID_W];
        maskTab[wrIdx] <= regWrData[RID_W-1:0];
      end
      if (stb.wrLower) begin
        enTab[wrIdx]  <= regWrData[WORD_W-1];
        sidTab[wrIdx] <= regWrData[SID_W-1:0];
      end
    end
  end

  // ID relative to the controller's first bus
  assign relRid = reqRid - {baseBus, 8'h00};

  // one comparator per entry
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gCmp
    assign matchVec[g] = enTab[g] &
                         (((relRid ^ ridTab[g]) & ~maskTab[g]) == '0);
  end

  // lowest index wins: scan downward so the last write is the lowest
  always_comb begin
    selSid = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selSid = sidTab[i];
    end
  end

  assign anyHit = |matchVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respSid   <= '0;
    end else begin
      respValid <= stb.lookup;
      respHit   <= stb.lookup & anyHit;
      respSid   <= (stb.lookup & anyHit) ? selSid : '0;
    end
  end

endmodule

// File: rtl/rid_stream_map.sv
module rid_stream_map
  import rid_map_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int SID_W = 10,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [IDX_W:0]    regAddr,
  input  logic [31:0]       regWrData,
  input  logic [7:0]        baseBus,
  input  logic              reqValid,
  input  logic [15:0]       reqRid,
  output logic              respValid,
  output logic              respHit,
  output logic [SID_W-1:0]  respSid,
  input  logic              allocReq,
  output logic [IDX_W-1:0]  allocIdx,
  output logic              allocFull
);

  ctlStrobes_t      stb;
  logic [IDX_W-1:0] wrIdx;

  rid_map_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W(IDX_W)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .reqValid(reqValid),
    .allocReq(allocReq),
    .stb(stb),
    .wrIdx(wrIdx),
    .allocIdx(allocIdx),
    .allocFull(allocFull)
  );

  rid_map_dp #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .SID_W(SID_W),
    .IDX_W(IDX_W)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .wrIdx(wrIdx),
    .regWrData(regWrData),
    .baseBus(baseBus),
    .reqRid(reqRid),
    .respValid(respValid),
    .respHit(respHit),
    .respSid(respSid)
  );

endmodule

// File: rtl/rid_map_chk.sv
module rid_map_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int SID_W = 10,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             respValid,
  input logic             respHit,
  input logic [SID_W-1:0] respSid,
  input logic             allocReq,
  input logic [IDX_W-1:0] allocIdx,
  input logic             allocFull
);

  p_resp_follows_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!respValid && !respHit && respSid == '0));

  p_miss_zero_sid_r7: assert property (@(posedge clk) disable iff (!rstN)
    !respHit |-> respSid == '0);

  p_full_idx_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    allocFull |-> allocIdx == '0);

  p_full_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    allocFull |=> allocFull);

  p_alloc_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!allocReq && !allocFull) |=> $stable(allocIdx));

  p_alloc_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (allocReq && !allocFull && allocIdx != IDX_W'(NUM_ENTRIES - 1))
      |=> allocIdx == $past(allocIdx) + IDX_W'(1));

endmodule

bind rid_stream_map rid_map_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .SID_W(SID_W),
  .IDX_W(IDX_W)
) uChk (
  .clk(clk),
  .rstN(rstN),
  .reqValid(reqValid),
  .respValid(respValid),
  .respHit(respHit),
  .respSid(respSid),
  .allocReq(allocReq),
  .allocIdx(allocIdx),
  .allocFull(allocFull)
);

// File: tb/sim_rid_stream_map.sv
`timescale 1ns/1ps
module sim_rid_stream_map;

  localparam int N = 8;
  localparam int SW = 10;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [IW:0]   regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [7:0]    baseBus = '0;
  logic          reqValid = 1'b0;
  logic [15:0]   reqRid = '0;
  logic          respValid;
  logic          respHit;
  logic [SW-1:0] respSid;
  logic          allocReq = 1'b0;
  logic [IW-1:0] allocIdx;
  logic          allocFull;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  rid_stream_map #(.NUM_ENTRIES(N), .SID_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .baseBus(baseBus), .reqValid(reqValid),
    .reqRid(reqRid), .respValid(respValid), .respHit(respHit),
    .respSid(respSid), .allocReq(allocReq), .allocIdx(allocIdx),
    .allocFull(allocFull)
  );

  // behavioural reference model
  logic [15:0]   mRid  [N];
  logic [15:0]   mMask [N];
  logic [SW-1:0] mSid  [N];
  bit            mEn   [N];
  bit            eValid = 0, eHit = 0;
  logic [SW-1:0] eSid = '0;
  int            eUsed = 0;

  initial for (int i = 0; i < N; i++) begin
    mRid[i] = '0; mMask[i] = '0; mSid[i] = '0; mEn[i] = 0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mRid[i] = '0; mMask[i] = '0; mSid[i] = '0; mEn[i] = 0;
      end
      eValid = 0; eHit = 0; eSid = '0; eUsed = 0;
    end else begin
      logic [15:0] rel;
      int idx;
      rel = reqRid - {baseBus, 8'h00};
      eValid = reqValid; eHit = 0; eSid = '0;
      if (reqValid) begin
        for (int i = 0; i < N; i++) begin
          if (!eHit && mEn[i] && (((rel ^ mRid[i]) & ~mMask[i]) == 16'h0)) begin
            eHit = 1; eSid = mSid[i];
          end
        end
      end
      idx = int'(regAddr[IW:1]);
      if (regWrEn) begin
        if (!regAddr[0]) begin
          mRid[idx] = regWrData[31:16]; mMask[idx] = regWrData[15:0];
        end else begin
          mEn[idx] = regWrData[31]; mSid[idx] = regWrData[SW-1:0];
        end
      end
      if (allocReq && eUsed < N) eUsed++;
    end
    #2;
    if (rstN || total > 0) begin
      check(tag, {31'd0, respValid}, {31'd0, eValid}, "respValid");
      check(tag, {31'd0, respHit}, {31'd0, eHit}, "respHit");
      check(tag, 32'(respSid), 32'(eSid), "respSid");
      check(tag, {31'd0, allocFull}, {31'd0, eUsed == N}, "allocFull");
      check(tag, 32'(allocIdx), (eUsed == N) ? 32'd0 : 32'(eUsed), "allocIdx");
    end
  end

  task automatic wrWord(input int idx, input bit lower, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = {IW'(idx), lower}; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic look(input logic [15:0] rid);
    reqValid = 1'b1; reqRid = rid;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // directed check just after a lookup
  task automatic expectResp(input string req, input bit hit, input int sid);
    check(req, {31'd0, respHit}, {31'd0, hit}, "directed hit");
    check(req, 32'(respSid), 32'(sid), "directed sid");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1", {31'd0, respValid}, 32'd0, "reset respValid");
    check("R1", 32'(allocIdx), 32'd0, "reset allocIdx");
    rstN = 1'b1;
    @(negedge clk);
    look(16'h0000);  // empty table: all disabled
    expectResp("R1", 0, 0);

    tag = "R2";
    wrWord(0, 0, 32'h0108_0000);
    tag = "R3";
    wrWord(0, 1, 32'h8000_0005 | 32'h7FFF_FC00);
    tag = "R4";
    look(16'h0108); expectResp("R4", 1, 5);
    look(16'h0109); expectResp("R7", 0, 0);
    wrWord(1, 0, 32'h0200_00FF);
    wrWord(1, 1, 32'h8000_0009);
    look(16'h02AB); expectResp("R4", 1, 9);
    tag = "R7";
    look(16'h0300); expectResp("R7", 0, 0);

    tag = "R5";
    wrWord(2, 0, 32'h0400_0000);
    wrWord(2, 1, 32'h0000_0007);
    look(16'h0400); expectResp("R5", 0, 0);
    wrWord(2, 1, 32'h8000_0007);
    look(16'h0400); expectResp("R5", 1, 7);

    tag = "R6";
    wrWord(3, 0, 32'h0210_0000);
    wrWord(3, 1, 32'h8000_000B);
    look(16'h0210); expectResp("R6", 1, 9);
    wrWord(1, 1, 32'h0000_0009);
    look(16'h0210); expectResp("R6", 1, 11);

    tag = "R8";
    reqValid = 1'b1; reqRid = 16'h0108;
    @(negedge clk); reqRid = 16'h0400;
    @(negedge clk); reqValid = 1'b0;
    repeat (2) @(negedge clk);

    tag = "R9";
    baseBus = 8'h10;
    look(16'h1108); expectResp("R9", 1, 5);
    look(16'h0108); expectResp("R9", 0, 0);
    baseBus = 8'hFF;
    look(16'h0008); expectResp("R9", 1, 5);  // wraps to 0x0108
    baseBus = 8'h00;

    tag = "R11";
    regWrEn = 1'b1; regAddr = {IW'(0), 1'b1}; regWrData = 32'h0000_0005;
    reqValid = 1'b1; reqRid = 16'h0108;
    @(negedge clk);
    regWrEn = 1'b0; reqValid = 1'b0;
    expectResp("R11", 1, 5);
    look(16'h0108); expectResp("R11", 0, 0);

    tag = "R10";
    for (int k = 0; k < N + 3; k++) begin
      allocReq = 1'b1;
      @(negedge clk);
      allocReq = 1'b0;
      @(negedge clk);
    end
    check("R10", {31'd0, allocFull}, 32'd1, "full after grants");
    check("R10", 32'(allocIdx), 32'd0, "idx when full");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule